// File: doc/BRIEF.md
# Static Memory Bus Cycle Generator

This block produces the external bus cycles for SRAM-type devices wired directly to a 16-bit or 32-bit data bus. A requester presents one access: an address, a size, a direction and a flag asking for a whole cache-line transfer. While idle, the block accepts it and runs one or more bus beats. Each beat is a T1 clock, then an optional run of wait clocks (TW), then a T2 clock. During the beat the block drives a one-clock bus-start strobe, a chip select, a read strobe and per-byte write enables, all active low. It also drives the beat address and the write data steered onto the bus lanes.

A line transfer always moves 16 bytes as longwords, whatever the requested size. It runs as 4 beats on a 32-bit bus or 8 beats on a 16-bit bus, and the beats follow each other with no idle clock between them. The requester supplies each longword of a line write live on `req_wdata`. It selects that longword using `line_word`. For single writes the block latches the data when it accepts the request. A one-clock `ready` pulse marks the last T2 of the transaction.

The state machine has four states:
- `ST_IDLE`: accept when `req_valid` is high.
- `ST_T1`: go to `ST_TW` if the effective wait count is nonzero, otherwise go to `ST_T2`.
- `ST_TW`: stay while waits remain or while the external wait is held; leave to `ST_T2`.
- `ST_T2`: go to `ST_T1` if beats remain, otherwise return to `ST_IDLE`.

Top module: `sram_cycle_gen`

## Requirements
- R1: While reset is held and while idle, `bs_n`, `cs_n` and `rd_n` are 1, `we_n` is 4'b1111 and `ready` is 0.
- R2: A request seen in idle at a rising edge makes the next clock T1. `bs_n` is 0 in T1 only. A zero-wait beat lasts exactly two clocks.
- R3: `cs_n` is 0 from the start of T1 until the falling clock edge inside T2. It is 1 for the second half of every T2, including between back-to-back beats.
- R4: On reads, `rd_n` is 0 for the whole beat and `we_n` stays 4'b1111. The first beat drives the exact request address, with no size indication.
- R5: Sizes are encoded 0 = byte, 1 = word, 2 = longword. On a write beat only the addressed lanes have `we_n` low; lane i carries the byte at address offset i. On a 32-bit bus: a byte uses lane addr[1:0]; a word uses lanes 1:0 or, when addr[1] is 1, lanes 3:2; a longword uses all lanes. On a 16-bit bus: a byte uses lane addr[0]; a word or a longword beat uses lanes 1:0. Lanes 3:2 are never enabled on a 16-bit bus.
- R6: On a 16-bit bus a single longword takes two beats, at addresses addr and addr+2. `bus_wdata[15:0]` carries data bits 31:16 when the beat address has bit 1 set, and bits 15:0 otherwise. On a 32-bit bus, `bus_wdata` is the whole word.
- R7: A line transfer ignores size and the low 4 address bits. It runs 4 beats (step 4) on a 32-bit bus or 8 beats (step 2) on a 16-bit bus, with T2 followed directly by T1. Its writes enable every lane of the bus width. `line_word` gives the longword index, which is beat index on a 32-bit bus and beat index / 2 on a 16-bit bus.
- R8: `cfg_wait` is clamped to 10 and inserts that many wait clocks between T1 and T2. `ext_wait` is sampled at the end of the last wait clock, and each high sample adds one more clock. With zero programmed waits, `ext_wait` is ignored.
- R9: `ready` is 1 only in the final T2, and the following clock is idle. A request raised while a transaction is running is ignored: it causes no bus activity during or after the transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Access request |
| req_addr | input | 32 | Byte address of the access |
| req_size | input | 2 | 0 byte, 1 word, 2 longword |
| req_write | input | 1 | 1 write, 0 read |
| req_line | input | 1 | 16-byte line transfer |
| req_wdata | input | 32 | Write data; live per longword during line writes |
| cfg_bus32 | input | 1 | 1 for 32-bit bus, 0 for 16-bit bus |
| cfg_wait | input | 4 | Programmed wait clocks (clamped to 10) |
| ext_wait | input | 1 | External wait request, active high |
| bus_addr | output | 32 | Beat address |
| bus_wdata | output | 32 | Write data on bus lanes |
| bs_n | output | 1 | Bus-start strobe, active low |
| cs_n | output | 1 | Chip select, active low |
| rd_n | output | 1 | Read strobe, active low |
| we_n | output | 4 | Per-lane write enables, active low |
| line_word | output | 2 | Longword index within a line transfer |
| ready | output | 1 | Transaction complete pulse |

## Verification
Beat k of a transaction begins k·P clocks after the accepting edge, where P = 2 + effective waits + external extension. `ready` is due in clock beats·P − 1, and the idle clock follows at beats·P. The bench steps one clock at a time from the accepting edge and samples each output 1 ns after the rising edge. It also samples `cs_n` 1 ns after the falling edge, so that the half-cycle gap of T2 is seen in its own half. The sweep covers both bus widths, every size, both directions and every legal start offset. Further runs cover the lengths and addresses of line transfers, the wait clamp, wait extension and idle-only acceptance.

// File: rtl/sram_bus_pkg.sv
package sram_bus_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_T1   = 2'd1,
        ST_TW   = 2'd2,
        ST_T2   = 2'd3
    } bus_state_e;
endpackage

// File: rtl/sram_beat_plan.sv
module sram_beat_plan
    import sram_bus_pkg::*;
#(
    parameter int AW         = 32,
    parameter int LINE_BYTES = 16,
    parameter int BEAT_W     = 4,
    parameter int LW_W       = 2
) (
    input  logic [AW-1:0]     addr,
    input  acc_size_e         size,
    input  logic              line,
    input  logic              bus32,
    input  logic [BEAT_W-1:0] beat,
    output logic [BEAT_W-1:0] nbeats,
    output logic [AW-1:0]     beat_addr,
    output logic [3:0]        lanes,
    output logic [LW_W-1:0]   line_word
);
    localparam int BEATS32 = LINE_BYTES / 4;
    localparam int BEATS16 = LINE_BYTES / 2;

    logic [AW-1:0] beat_ext;
    logic [AW-1:0] line_base;

    assign beat_ext  = AW'(beat);
    assign line_base = addr & ~AW'(LINE_BYTES - 1);

    always_comb begin
        if (line) begin
            nbeats    = bus32 ? BEAT_W'(BEATS32) : BEAT_W'(BEATS16);
            beat_addr = line_base + (bus32 ? (beat_ext << 2) : (beat_ext << 1));
            lanes     = bus32 ? 4'b1111 : 4'b0011;
        end else begin
            nbeats    = (size == SZ_LONG && !bus32) ? BEAT_W'(2) : BEAT_W'(1);
            beat_addr = addr + (beat_ext << 1);
            unique case (size)
                SZ_BYTE: lanes = bus32 ? (4'b0001 << addr[1:0]) : (4'b0001 << addr[0]);
                SZ_WORD: lanes = (bus32 && addr[1]) ? 4'b1100 : 4'b0011;
                default: lanes = bus32 ? 4'b1111 : 4'b0011;
            endcase
        end
        line_word = bus32 ? beat[LW_W-1:0] : beat[LW_W:1];
    end
endmodule

// File: rtl/sram_wait_ctr.sv
module sram_wait_ctr #(
    parameter int WAIT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WAIT_W-1:0] load_val,
    input  logic              step,
    output logic              last
);
    logic [WAIT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (step && cnt_q > WAIT_W'(1)) begin
            cnt_q <= cnt_q - WAIT_W'(1);
        end
    end

    assign last = (cnt_q == WAIT_W'(1));
endmodule

// File: rtl/sram_cs_gap.sv
module sram_cs_gap (
    input  logic clk,
    input  logic rst_n,
    input  logic in_t2,
    output logic gap
);
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap <= 1'b0;
        end else begin
            gap <= in_t2;
        end
    end
endmodule

// File: rtl/sram_cycle_gen.sv
module sram_cycle_gen
    import sram_bus_pkg::*;
#(
    parameter int AW         = 32,
    parameter int DW         = 32,
    parameter int WAIT_W     = 4,
    parameter int MAX_WAIT   = 10,
    parameter int LINE_BYTES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [AW-1:0]     req_addr,
    input  logic [1:0]        req_size,
    input  logic              req_write,
    input  logic              req_line,
    input  logic [DW-1:0]     req_wdata,
    input  logic              cfg_bus32,
    input  logic [WAIT_W-1:0] cfg_wait,
    input  logic              ext_wait,
    output logic [AW-1:0]     bus_addr,
    output logic [DW-1:0]     bus_wdata,
    output logic              bs_n,
    output logic              cs_n,
    output logic              rd_n,
    output logic [3:0]        we_n,
    output logic [1:0]        line_word,
    output logic              ready
);
    localparam int BEAT_W = $clog2(LINE_BYTES / 2) + 1;
    localparam int LW_W   = $clog2(LINE_BYTES / 4);
    localparam int HALF   = DW / 2;

    bus_state_e        state_q, state_d;
    logic [AW-1:0]     addr_q;
    acc_size_e         size_q;
    logic              write_q, line_q, bus32_q;
    logic [DW-1:0]     wdata_q;
    logic [BEAT_W-1:0] beat_q, nbeats;
    logic [3:0]        lanes;
    logic [LW_W-1:0]   lw_idx;
    logic [WAIT_W-1:0] wait_eff;
    logic              last_wait, last_beat, accept, gap, cs_on;
    logic [DW-1:0]     wsrc;

    assign wait_eff  = (cfg_wait > WAIT_W'(MAX_WAIT)) ? WAIT_W'(MAX_WAIT) : cfg_wait;
    assign accept    = (state_q == ST_IDLE) && req_valid;
    assign last_beat = (beat_q == nbeats - BEAT_W'(1));

    sram_beat_plan #(.AW(AW), .LINE_BYTES(LINE_BYTES), .BEAT_W(BEAT_W), .LW_W(LW_W)) u_plan (
        .addr(addr_q), .size(size_q), .line(line_q), .bus32(bus32_q), .beat(beat_q),
        .nbeats(nbeats), .beat_addr(bus_addr), .lanes(lanes), .line_word(lw_idx)
    );

    sram_wait_ctr #(.WAIT_W(WAIT_W)) u_wait (
        .clk(clk), .rst_n(rst_n), .load(state_q == ST_T1), .load_val(wait_eff),
        .step(state_q == ST_TW), .last(last_wait)
    );

    sram_cs_gap u_gap (.clk(clk), .rst_n(rst_n), .in_t2(state_q == ST_T2), .gap(gap));

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid) state_d = ST_T1;
            ST_T1:   state_d = (wait_eff == '0) ? ST_T2 : ST_TW;
            ST_TW:   if (last_wait && !ext_wait) state_d = ST_T2;
            ST_T2:   state_d = last_beat ? ST_IDLE : ST_T1;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register and request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            size_q  <= SZ_BYTE;
            write_q <= 1'b0;
            line_q  <= 1'b0;
            bus32_q <= 1'b1;
            wdata_q <= '0;
            beat_q  <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                addr_q  <= req_addr;
                size_q  <= acc_size_e'(req_size);
                write_q <= req_write;
                line_q  <= req_line;
                bus32_q <= cfg_bus32;
                wdata_q <= req_wdata;
                beat_q  <= '0;
            end else if (state_q == ST_T2 && !last_beat) begin
                beat_q <= beat_q + BEAT_W'(1);
            end
        end
    end

    // outputs
    always_comb begin
        cs_on     = (state_q != ST_IDLE);
        bs_n      = (state_q != ST_T1);
        cs_n      = !cs_on || (gap && state_q == ST_T2);
        rd_n      = !(cs_on && !write_q);
        we_n      = (cs_on && write_q) ? ~lanes : 4'b1111;
        ready     = (state_q == ST_T2) && last_beat;
        line_word = 2'(lw_idx);
        wsrc      = line_q ? req_wdata : wdata_q;
        if (bus32_q) bus_wdata = wsrc;
        else         bus_wdata = {{HALF{1'b0}}, bus_addr[1] ? wsrc[DW-1:HALF] : wsrc[HALF-1:0]};
    end

    // R2
    bs_single_chk: assert property (@(posedge clk) disable iff (!rst_n) !bs_n |=> bs_n);
    // R9
    ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) ready |=> (state_q == ST_IDLE && cs_n));
    // R4
    read_no_we_chk: assert property (@(posedge clk) disable iff (!rst_n) !rd_n |-> (we_n == 4'b1111));
    // R5
    narrow_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus32_q && state_q != ST_IDLE) |-> (we_n[3:2] == 2'b11));
    // R8
    ext_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TW && last_wait && ext_wait) |=> (state_q == ST_TW));
    // R7
    line_no_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_T2 && line_q && !ready) |=> (!bs_n && !cs_n));
endmodule

// File: tb/sram_cycle_gen_bench.sv
`timescale 1ns/100ps
module sram_cycle_gen_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic        req_write = 1'b0;
    logic        req_line = 1'b0;
    logic [31:0] req_wdata = '0;
    logic        cfg_bus32 = 1'b1;
    logic [3:0]  cfg_wait = '0;
    logic        ext_wait = 1'b0;
    logic [31:0] bus_addr, bus_wdata;
    logic        bs_n, cs_n, rd_n, ready;
    logic [3:0]  we_n;
    logic [1:0]  line_word;

    int nchk = 0;
    int nfail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    sram_cycle_gen u_sram_cycle_gen (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_size(req_size), .req_write(req_write), .req_line(req_line),
        .req_wdata(req_wdata), .cfg_bus32(cfg_bus32), .cfg_wait(cfg_wait),
        .ext_wait(ext_wait), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bs_n(bs_n), .cs_n(cs_n), .rd_n(rd_n), .we_n(we_n),
        .line_word(line_word), .ready(ready)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic int f_beats(input int sz, input bit ln, input bit b32);
        if (ln) return b32 ? 4 : 8;
        return (sz == 2 && !b32) ? 2 : 1;
    endfunction

    function automatic logic [31:0] f_addr(input logic [31:0] a, input bit ln, input bit b32, input int b);
        if (ln) return (a & 32'hFFFF_FFF0) + 32'(b * (b32 ? 4 : 2));
        return a + 32'(2 * b);
    endfunction

    function automatic logic [3:0] f_lanes(input logic [31:0] a, input int sz, input bit ln, input bit b32);
        if (ln || sz == 2) return b32 ? 4'b1111 : 4'b0011;
        if (sz == 0) return b32 ? (4'b0001 << a[1:0]) : (4'b0001 << a[0]);
        return (b32 && a[1]) ? 4'b1100 : 4'b0011;
    endfunction

    task automatic idle_chk(input string tag);
        chk(bs_n && cs_n && rd_n && we_n == 4'hF && !ready, tag,
            {26'd0, bs_n, cs_n, rd_n, ready, 2'd0}, 32'h38);
    endtask

    task automatic run(input logic [31:0] a, input int sz, input bit wr, input bit ln,
                       input bit b32, input int w, input int e, input bit poke);
        int weff = (w > 10) ? 10 : w;
        int ee   = (weff == 0) ? 0 : e;
        int p    = 2 + weff + ee;
        int nb   = f_beats(sz, ln, b32);
        int tot  = nb * p;
        logic [31:0] wd = 32'hA1B2_C3D4 ^ a;
        cfg_bus32 = b32; cfg_wait = 4'(w); ext_wait = (e > 0);
        req_addr = a; req_size = 2'(sz); req_write = wr; req_line = ln; req_wdata = wd;
        @(negedge clk) req_valid = 1'b1;
        @(posedge clk);
        for (int k = 0; k < tot; k++) begin
            int b  = k / p;
            int ph = k % p;
            logic [31:0] ea = f_addr(a, ln, b32, b);
            logic [31:0] ed = b32 ? wd : {16'h0, ea[1] ? wd[31:16] : wd[15:0]};
            #1;
            chk(bs_n == (ph != 0), "R2 bs_n", {31'd0, bs_n}, {31'd0, ph != 0});
            chk(ready == (k == tot - 1), "R9 ready", {31'd0, ready}, {31'd0, k == tot - 1});
            chk(cs_n == 1'b0, "R3 cs_n first half", {31'd0, cs_n}, 32'd0);
            chk(rd_n == wr, "R4 rd_n", {31'd0, rd_n}, {31'd0, wr});
            chk(we_n == (wr ? ~f_lanes(a, sz, ln, b32) : 4'hF), "R5 we_n",
                {28'd0, we_n}, {28'd0, wr ? ~f_lanes(a, sz, ln, b32) : 4'hF});
            chk(bus_addr == ea, ln ? "R7 line addr" : "R6 beat addr", bus_addr, ea);
            if (wr) chk(bus_wdata == ed, "R6 bus_wdata", bus_wdata, ed);
            if (ln) chk(line_word == 2'(b32 ? b : b / 2), "R7 line_word",
                        {30'd0, line_word}, 32'(b32 ? b : b / 2));
            #2;
            if (k == 0) req_valid = 1'b0;
            if (poke && k == 1) begin req_valid = 1'b1; req_addr = a ^ 32'h40; end
            if (poke && k == 2) req_valid = 1'b0;
            if (e > 0 && k == ((weff == 0) ? p - 1 : weff + e)) ext_wait = 1'b0;
            #0.5;
            chk(cs_n == (ph == p - 1), "R3 cs_n second half", {31'd0, cs_n}, {31'd0, ph == p - 1});
            @(posedge clk);
        end
        #1;
        idle_chk("R9 idle after ready");
        if (poke) begin
            for (int i = 0; i < 3; i++) begin
                @(posedge clk); #1;
                idle_chk("R9 busy request ignored");
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

    initial begin
        #1;
        idle_chk("R1 in reset");
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;
        idle_chk("R1 after reset");
        // R4 R5 R6: sweep of single accesses
        for (int b32 = 0; b32 < 2; b32++)
            for (int sz = 0; sz < 3; sz++)
                for (int wr = 0; wr < 2; wr++)
                    for (int wi = 0; wi < 2; wi++)
                        for (int off = 0; off < 4; off++)
                            if ((sz == 0) || (sz == 1 && off[0] == 1'b0) || (sz == 2 && off == 0))
                                run(32'h1000_0100 + 32'(off), sz, wr[0], 1'b0, b32[0], wi * 2, 0, 1'b0);
        // R7: line transfers at several start offsets and sizes
        for (int b32 = 0; b32 < 2; b32++)
            for (int wr = 0; wr < 2; wr++)
                for (int oi = 0; oi < 3; oi++)
                    run(32'h2000_0040 + 32'(oi == 0 ? 0 : (oi == 1 ? 6 : 14)), oi, wr[0], 1'b1,
                        b32[0], oi == 2 ? 1 : 0, 0, 1'b0);
        // R8: clamp, external extension, ignored with zero waits
        run(32'h3000_0000, 2, 1'b0, 1'b0, 1'b1, 13, 0, 1'b0);
        run(32'h3000_0010, 2, 1'b1, 1'b0, 1'b1, 15, 0, 1'b0);
        run(32'h3000_0020, 1, 1'b0, 1'b0, 1'b1, 1, 3, 1'b0);
        run(32'h3000_0030, 0, 1'b1, 1'b0, 1'b0, 2, 2, 1'b0);
        run(32'h3000_0040, 2, 1'b0, 1'b0, 1'b1, 0, 4, 1'b0);
        // R9: request while busy is ignored
        run(32'h4000_0000, 2, 1'b0, 1'b0, 1'b1, 3, 0, 1'b1);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule